// File: doc/BRIEF.md
# DDR SDRAM Start-Up Sequencer

This block sits on the controller side of a DDR SDRAM interface and, after a synchronous reset, steps the memory through its mandatory power-up ritual. It first holds the clock enable low with the command bus at NOP for a stable-clock interval. It then raises clock enable and issues a fixed series of commands: precharge-all, an extended-mode write that turns the DLL on, and a mode write that resets the DLL. A second precharge-all, a run of auto refreshes and a closing mode write with the DLL-reset bit cleared complete the series.

Every wait is a parameter counted in clock cycles, so the same RTL serves silicon timing and short simulation runs. The burst length, burst type and CAS latency placed into both mode writes come from static configuration pins that are captured while reset is held. Two flags tell the rest of the controller how far start-up has progressed. `init_done` rises when the memory will take ordinary traffic. `rd_allow` rises separately, once the DLL has had its lock window, and gates read commands.

Top module: `ddr_init_seq`

## Requirements
- R1: From reset release, for the first STABLE_CYC cycles (cycles 0 to STABLE_CYC-1), `cke` is 0 and the command pins {cs_n,ras_n,cas_n,we_n} are 4'b0111 (NOP).
- R2: At cycle STABLE_CYC, `cke` goes to 1 and stays at 1 until the next reset. NOP is driven for CKE_NOP_CYC cycles. A precharge-all follows: pins 4'b0010 with addr bit 8 set, ba 0, and all other addr bits 0.
- R3: T_RP cycles after the first precharge-all, an extended mode write is issued: pins 4'b0000, ba = 2'b01, addr all zero (DLL enabled, reserved bits zero).
- R4: T_MRD cycles after the extended write, a DLL-reset mode write is issued: pins 4'b0000, ba = 2'b00, addr bit 8 = 1, addr[6:4] = latency code, addr[3] = burst type, addr[2:0] = burst-length code, and all other addr bits 0.
- R5: Field codes are fixed. With `cfg_cl4`=0 the latency code is 3'b011, and with 1 it is 3'b100. With `cfg_bl_sel` 0/1/2/3 the burst-length code is 3'b001/3'b010/3'b011/3'b011. `cfg_interleave` is copied to addr bit 3.
- R6: Configuration inputs are captured while `rst_n` is low. Changes to them after reset release do not alter the mode writes.
- R7: T_MRD cycles after the DLL-reset write, a second precharge-all is issued (same encoding as R2). T_RP cycles after it, the first of REF_COUNT auto refreshes is issued: pins 4'b0001, addr 0, ba 0. Each later refresh comes T_RFC cycles after the previous one.
- R8: T_RFC cycles after the last refresh, a final mode write is issued with the same fields as R4 but addr bit 8 = 0.
- R9: `init_done` is 0 until T_MRD cycles after the final mode write. It then stays 1 until reset.
- R10: `rd_allow` rises exactly LOCK_CYC cycles after the cycle of the DLL-reset mode write and stays 1 until reset.
- R11: Every cycle other than the listed command slots drives NOP with addr and ba at zero, and this includes every cycle after `init_done` rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Synchronous active-low reset; configuration is captured while low |
| cfg_cl4 | input | 1 | Latency select: 0 gives 3 cycles, 1 gives 4 cycles |
| cfg_bl_sel | input | 2 | Burst-length select: 0 gives 2, 1 gives 4, 2 or 3 gives 8 |
| cfg_interleave | input | 1 | Burst order: 0 sequential, 1 interleaved |
| cke | output | 1 | Memory clock enable |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| addr | output | ADDR_W | Address bus carrying opcodes and the precharge-all bit |
| ba | output | BA_W | Bank address, selects which mode register is written |
| init_done | output | 1 | Start-up series complete; sticky until reset |
| rd_allow | output | 1 | DLL lock window elapsed; reads may be issued |

## Verification
The assertions assume that every wait parameter is at least 2, so that two commands are never adjacent. They also assume that `rst_n` is the only control input, and that the configuration pins are steady while reset is low. The bench applies each configuration before asserting reset. It then perturbs the configuration pins only after release, which checks that the perturbation is ignored. Short wait values, all 2 or more, keep the runs brief while still covering every gap. Each configuration is followed cycle by cycle against a timeline computed from the parameters.

// File: rtl/ddr_init_pkg.sv
// Shared types for the DDR start-up sequencer: step encoding, command pin
// patterns and the mode-register field encoders.
package ddr_init_pkg;

    typedef enum logic [3:0] {
        ST_STABLE,   // clock-enable low, waiting for stable clock
        ST_CKE,      // clock-enable high, NOP padding
        ST_PRE_A,    // first precharge-all
        ST_EMRS,     // extended mode write, DLL on
        ST_MRS_RST,  // mode write with DLL reset
        ST_PRE_B,    // second precharge-all
        ST_REF,      // auto refresh loop
        ST_MRS_OP,   // mode write without DLL reset
        ST_DONE      // finished
    } init_step_e;

    typedef struct packed {
        logic cs_n;
        logic ras_n;
        logic cas_n;
        logic we_n;
    } cmd_pins_t;

    localparam cmd_pins_t PINS_NOP  = '{cs_n: 1'b0, ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1};
    localparam cmd_pins_t PINS_PRE  = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b1, we_n: 1'b0};
    localparam cmd_pins_t PINS_MODE = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b0, we_n: 1'b0};
    localparam cmd_pins_t PINS_REF  = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b0, we_n: 1'b1};

    // Latency field code for the mode register.
    function automatic logic [2:0] lat_code(input logic cl4);
        return cl4 ? 3'b100 : 3'b011;
    endfunction

    // Burst-length field code; both upper selects map to eight beats.
    function automatic logic [2:0] len_code(input logic [1:0] sel);
        case (sel)
            2'd0:    return 3'b001;
            2'd1:    return 3'b010;
            default: return 3'b011;
        endcase
    endfunction

endpackage

// File: rtl/ddr_init_timer.sv
// Down-counter that paces the sequencer steps.
// Assumes: load has priority; count holds at zero until reloaded.
module ddr_init_timer #(
    parameter int CNT_W   = 16,
    parameter int RST_VAL = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);
    logic [CNT_W-1:0] cnt_q;

    // Count down toward zero, reload on request, preset under reset.
    always_ff @(posedge clk) begin
        if (!rst_n)              cnt_q <= CNT_W'(RST_VAL);
        else if (load)           cnt_q <= load_val;
        else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
    end

    assign expired = (cnt_q == '0);
endmodule

// File: rtl/ddr_init_lock.sv
// DLL lock window: raises unlocked exactly LOCK_CYC cycles after the cycle in
// which start is high. Assumes LOCK_CYC >= 2 and a single start per reset.
module ddr_init_lock #(
    parameter int LOCK_CYC = 200
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic unlocked
);
    localparam int LW = $clog2(LOCK_CYC + 1);

    logic [LW-1:0] cnt_q;
    logic          run_q;
    logic          done_q;

    // Arm on start, count the window, latch completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            run_q  <= 1'b0;
            done_q <= 1'b0;
        end else if (start) begin
            cnt_q  <= LW'(LOCK_CYC - 1);
            run_q  <= 1'b1;
        end else if (run_q) begin
            cnt_q <= cnt_q - 1'b1;
            if (cnt_q == LW'(1)) begin
                done_q <= 1'b1;
                run_q  <= 1'b0;
            end
        end
    end

    assign unlocked = done_q;
endmodule

// File: rtl/ddr_init_enc.sv
// Maps the current step and the issue strobe onto command pins, address and
// bank address. Assumes ADDR_W >= 9 and BA_W >= 1. Purely combinational.
module ddr_init_enc
    import ddr_init_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int BA_W   = 2
) (
    input  init_step_e        step,
    input  logic              issue,
    input  logic              cl4,
    input  logic [1:0]        bl_sel,
    input  logic              interleave,
    output logic              cs_n,
    output logic              ras_n,
    output logic              cas_n,
    output logic              we_n,
    output logic [ADDR_W-1:0] addr,
    output logic [BA_W-1:0]   ba
);
    cmd_pins_t  pins;
    logic [6:0] mode_low;

    assign mode_low = {lat_code(cl4), interleave, len_code(bl_sel)};

    // Select the pin pattern and operand for the step being issued.
    always_comb begin
        pins = PINS_NOP;
        addr = '0;
        ba   = '0;
        if (issue) begin
            case (step)
                ST_PRE_A, ST_PRE_B: begin
                    pins    = PINS_PRE;
                    addr[8] = 1'b1;
                end
                ST_EMRS: begin
                    pins = PINS_MODE;
                    ba   = BA_W'(1);
                end
                ST_MRS_RST: begin
                    pins      = PINS_MODE;
                    addr[8]   = 1'b1;
                    addr[6:0] = mode_low;
                end
                ST_REF:  pins = PINS_REF;
                ST_MRS_OP: begin
                    pins      = PINS_MODE;
                    addr[6:0] = mode_low;
                end
                default: pins = PINS_NOP;
            endcase
        end
    end

    assign cs_n  = pins.cs_n;
    assign ras_n = pins.ras_n;
    assign cas_n = pins.cas_n;
    assign we_n  = pins.we_n;
endmodule

// File: rtl/ddr_init_seq.sv
// DDR SDRAM start-up sequencer top. Walks a fixed step list, each step one
// command cycle followed by NOP padding up to its wait parameter, then holds.
// Assumes all wait parameters >= 2, REF_COUNT >= 1, config steady in reset.
module ddr_init_seq
    import ddr_init_pkg::*;
#(
    parameter int ADDR_W      = 12,
    parameter int BA_W        = 2,
    parameter int STABLE_CYC  = 25000,
    parameter int CKE_NOP_CYC = 2,
    parameter int T_RP        = 3,
    parameter int T_MRD       = 2,
    parameter int T_RFC       = 10,
    parameter int REF_COUNT   = 2,
    parameter int LOCK_CYC    = 200
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_cl4,
    input  logic [1:0]        cfg_bl_sel,
    input  logic              cfg_interleave,
    output logic              cke,
    output logic              cs_n,
    output logic              ras_n,
    output logic              cas_n,
    output logic              we_n,
    output logic [ADDR_W-1:0] addr,
    output logic [BA_W-1:0]   ba,
    output logic              init_done,
    output logic              rd_allow
);
    localparam int MAX_A = (STABLE_CYC > CKE_NOP_CYC) ? STABLE_CYC : CKE_NOP_CYC;
    localparam int MAX_B = (T_RP > T_MRD) ? T_RP : T_MRD;
    localparam int MAX_C = (MAX_B > T_RFC) ? MAX_B : T_RFC;
    localparam int MAX_D = (MAX_A > MAX_C) ? MAX_A : MAX_C;
    localparam int CNT_W = $clog2(MAX_D + 1);
    localparam int REF_W = $clog2(REF_COUNT + 1);

    init_step_e       step_q, step_nxt;
    logic             issue_q;
    logic [REF_W-1:0] refs_left_q;
    logic             cl4_q, intl_q;
    logic [1:0]       bl_q;
    logic             expired, advance, repeat_ref;
    logic [CNT_W-1:0] load_val;

    // Wait length of a step, less the cycle already spent on entry.
    function automatic logic [CNT_W-1:0] step_len(input init_step_e s);
        case (s)
            ST_CKE:                         return CNT_W'(CKE_NOP_CYC - 1);
            ST_PRE_A, ST_PRE_B:             return CNT_W'(T_RP - 1);
            ST_EMRS, ST_MRS_RST, ST_MRS_OP: return CNT_W'(T_MRD - 1);
            ST_REF:                         return CNT_W'(T_RFC - 1);
            default:                        return '0;
        endcase
    endfunction

    // Fixed successor of each step.
    always_comb begin
        case (step_q)
            ST_STABLE:  step_nxt = ST_CKE;
            ST_CKE:     step_nxt = ST_PRE_A;
            ST_PRE_A:   step_nxt = ST_EMRS;
            ST_EMRS:    step_nxt = ST_MRS_RST;
            ST_MRS_RST: step_nxt = ST_PRE_B;
            ST_PRE_B:   step_nxt = ST_REF;
            ST_REF:     step_nxt = ST_MRS_OP;
            default:    step_nxt = ST_DONE;
        endcase
    end

    assign advance    = expired && (step_q != ST_DONE);
    assign repeat_ref = (step_q == ST_REF) && (refs_left_q != REF_W'(1));
    assign load_val   = repeat_ref ? step_len(ST_REF) : step_len(step_nxt);

    ddr_init_timer #(.CNT_W(CNT_W), .RST_VAL(STABLE_CYC - 1)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (advance),
        .load_val (load_val),
        .expired  (expired)
    );

    // Capture static configuration while reset is held.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cl4_q  <= cfg_cl4;
            bl_q   <= cfg_bl_sel;
            intl_q <= cfg_interleave;
        end
    end

    // Step register, refresh repeat count and one-cycle issue strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            step_q      <= ST_STABLE;
            issue_q     <= 1'b0;
            refs_left_q <= REF_W'(REF_COUNT);
        end else begin
            issue_q <= 1'b0;
            if (advance) begin
                if (repeat_ref) begin
                    refs_left_q <= refs_left_q - 1'b1;
                    issue_q     <= 1'b1;
                end else begin
                    step_q  <= step_nxt;
                    issue_q <= (step_nxt != ST_DONE);
                end
            end
        end
    end

    ddr_init_enc #(.ADDR_W(ADDR_W), .BA_W(BA_W)) u_enc (
        .step       (step_q),
        .issue      (issue_q),
        .cl4        (cl4_q),
        .bl_sel     (bl_q),
        .interleave (intl_q),
        .cs_n       (cs_n),
        .ras_n      (ras_n),
        .cas_n      (cas_n),
        .we_n       (we_n),
        .addr       (addr),
        .ba         (ba)
    );

    ddr_init_lock #(.LOCK_CYC(LOCK_CYC)) u_lock (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (issue_q && (step_q == ST_MRS_RST)),
        .unlocked (rd_allow)
    );

    assign cke       = (step_q != ST_STABLE);
    assign init_done = (step_q == ST_DONE);
endmodule

// File: rtl/ddr_init_seq_chk.sv
// Protocol checker for ddr_init_seq, attached by bind. Assumes all wait
// parameters are at least 2 so no two commands are adjacent.
module ddr_init_seq_chk #(
    parameter int ADDR_W = 12,
    parameter int BA_W   = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cke,
    input logic              cs_n,
    input logic              ras_n,
    input logic              cas_n,
    input logic              we_n,
    input logic [ADDR_W-1:0] addr,
    input logic [BA_W-1:0]   ba,
    input logic              init_done,
    input logic              rd_allow
);
    logic [3:0] pins;
    assign pins = {cs_n, ras_n, cas_n, we_n};

    p_quiet_until_cke_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !cke |-> pins == 4'b0111);

    p_cke_holds_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cke |=> cke);

    p_pre_all_bit_r2: assert property (@(posedge clk) disable iff (!rst_n)
        pins == 4'b0010 |-> addr[8]);

    p_ext_mode_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (pins == 4'b0000 && ba == BA_W'(1)) |-> addr == '0);

    p_mode_needs_cke_r4: assert property (@(posedge clk) disable iff (!rst_n)
        pins == 4'b0000 |-> cke);

    p_cmd_spacing_r7: assert property (@(posedge clk) disable iff (!rst_n)
        pins != 4'b0111 |=> pins == 4'b0111);

    p_done_holds_r9: assert property (@(posedge clk) disable iff (!rst_n)
        init_done |=> init_done);

    p_lock_holds_r10: assert property (@(posedge clk) disable iff (!rst_n)
        rd_allow |=> rd_allow);

    p_done_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
        init_done |-> (pins == 4'b0111 && addr == '0 && ba == '0));
endmodule

bind ddr_init_seq ddr_init_seq_chk #(.ADDR_W(ADDR_W), .BA_W(BA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cke       (cke),
    .cs_n      (cs_n),
    .ras_n     (ras_n),
    .cas_n     (cas_n),
    .we_n      (we_n),
    .addr      (addr),
    .ba        (ba),
    .init_done (init_done),
    .rd_allow  (rd_allow)
);

// File: tb/ddr_init_seq_tb.sv
// Sweeps all 16 configurations; each run is compared cycle by cycle against a
// timeline computed from the parameters.
module ddr_init_seq_tb;
    localparam int S     = 20;
    localparam int CN    = 3;
    localparam int RP    = 3;
    localparam int MRD   = 2;
    localparam int RFC   = 5;
    localparam int REFN  = 2;
    localparam int LOCK  = 40;
    localparam int T_PA  = S + CN;
    localparam int T_EM  = T_PA + RP;
    localparam int T_M1  = T_EM + MRD;
    localparam int T_PB  = T_M1 + MRD;
    localparam int T_R1  = T_PB + RP;
    localparam int T_M2  = T_R1 + REFN * RFC;
    localparam int T_DN  = T_M2 + MRD;
    localparam int T_RD  = T_M1 + LOCK;
    localparam int RUN_N = T_RD + 12;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_cl4 = 1'b0;
    logic [1:0]  cfg_bl_sel = 2'd0;
    logic        cfg_interleave = 1'b0;
    logic        cke, cs_n, ras_n, cas_n, we_n, init_done, rd_allow;
    logic [11:0] addr;
    logic [1:0]  ba;

    int vectors = 0;
    int errors  = 0;

    always #4 clk = ~clk;

    ddr_init_seq #(
        .ADDR_W(12), .BA_W(2), .STABLE_CYC(S), .CKE_NOP_CYC(CN), .T_RP(RP),
        .T_MRD(MRD), .T_RFC(RFC), .REF_COUNT(REFN), .LOCK_CYC(LOCK)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_cl4(cfg_cl4), .cfg_bl_sel(cfg_bl_sel),
        .cfg_interleave(cfg_interleave), .cke(cke), .cs_n(cs_n), .ras_n(ras_n),
        .cas_n(cas_n), .we_n(we_n), .addr(addr), .ba(ba),
        .init_done(init_done), .rd_allow(rd_allow)
    );

    task automatic chk(input string tag, input int n, input logic [31:0] act,
                       input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s cycle %0d: actual %h expected %h", tag, n, act, exp);
        end
    endtask

    // 0 NOP, 1 precharge-all, 2 ext mode, 3 DLL-reset mode, 4 refresh, 5 final mode
    function automatic int kind_at(input int n);
        if (n == T_PA || n == T_PB) return 1;
        if (n == T_EM) return 2;
        if (n == T_M1) return 3;
        if (n >= T_R1 && n < T_M2 && ((n - T_R1) % RFC) == 0) return 4;
        if (n == T_M2) return 5;
        return 0;
    endfunction

    task automatic run_cfg(input logic cl4, input logic [1:0] bsel, input logic intl);
        logic [6:0] low;
        int         k;
        logic [3:0] ep;
        logic [1:0] eb;
        logic [11:0] ea;
        string      tag;
        low = {(cl4 ? 3'b100 : 3'b011), intl, (bsel == 2'd0 ? 3'b001 :
               bsel == 2'd1 ? 3'b010 : 3'b011)};
        rst_n = 1'b0;
        cfg_cl4 = cl4; cfg_bl_sel = bsel; cfg_interleave = intl;
        repeat (3) @(negedge clk);
        // R1 / R9 / R10: state while reset is held
        chk("R1 reset", -1, {cke, cs_n, ras_n, cas_n, we_n}, 5'b00111);
        chk("R9 reset", -1, init_done, 1'b0);
        chk("R10 reset", -1, rd_allow, 1'b0);
        rst_n = 1'b1;
        for (int n = 0; n < RUN_N; n++) begin
            if (n == 5) begin
                // R6: perturb configuration after release
                cfg_cl4 = ~cl4; cfg_bl_sel = ~bsel; cfg_interleave = ~intl;
            end
            k = kind_at(n);
            ep = 4'b0111; eb = 2'b00; ea = 12'h000;
            tag = (n < S) ? "R1" : "R11";
            case (k)
                1: begin ep = 4'b0010; ea = 12'h100; tag = (n == T_PA) ? "R2" : "R7"; end
                2: begin ep = 4'b0000; eb = 2'b01; tag = "R3"; end
                3: begin ep = 4'b0000; ea = {4'b0001, 1'b0, low}; tag = "R4 R5 R6"; end
                4: begin ep = 4'b0001; tag = "R7"; end
                5: begin ep = 4'b0000; ea = {5'b00000, low}; tag = "R8 R5 R6"; end
                default: ;
            endcase
            chk(tag, n, {cs_n, ras_n, cas_n, we_n, ba, addr}, {ep, eb, ea});
            chk((n < S) ? "R1 cke" : "R2 cke", n, cke, (n >= S));
            chk("R9", n, init_done, (n >= T_DN));
            chk("R10", n, rd_allow, (n >= T_RD));
            @(negedge clk);
        end
    endtask

    initial begin
        for (int c = 0; c < 16; c++)
            run_cfg(c[0], c[2:1], c[3]);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        #(8 * 200000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule